// File: doc/BRIEF.md
# SMI Request Recognition Logic

This block decides when a system management interrupt request is taken by the core. The request pin is asynchronous and active low. The block first runs it through a synchronizer. An edge detector then turns each high-to-low transition into a single internal event. That event is held in a one-bit pending flag until the sequencer reports an instruction boundary outside a locked bus sequence. At that boundary the block emits a one-cycle take pulse and raises an in-handler flag.

The in-handler flag masks further servicing until the resume strobe marks the end of the handler. Edges that arrive while the handler runs are folded into the same single pending bit. After resume, that remembered request is taken at the very next boundary, so the two handlers run back to back. A pending SMI always beats an NMI request at the same boundary. The maskable-interrupt enable flag plays no part.

The edge detector has three states:
- EDG_ARMED waits for a low sample and fires, moving to EDG_LOW.
- EDG_LOW waits for the first high sample and moves to EDG_RECOVER.
- EDG_RECOVER counts consecutive high samples. It returns to EDG_ARMED after four of them, and falls back to EDG_LOW on any low sample, which does not fire.

The arbiter has two states:
- ARB_APP moves to ARB_SMM when it takes a pending request.
- ARB_SMM moves back to ARB_APP on resume.

Top module: `smi_gate`

## Requirements
- R1: One high-to-low transition of `smi_n` yields exactly one request, however many clocks the pin stays low; a long low level queues nothing extra.
- R2: A low level lasting a single clock is captured.
- R3: After a request, the detector re-arms only after `smi_n` has been sampled high on at least 4 consecutive clocks; a new low that follows fewer high samples produces no request.
- R4: A pending request is taken only on a clock where `boundary` is 1 and `locked` is 0; while either condition fails it stays pending without loss.
- R5: If `smi_n` is sampled low (detector armed, no handler running) on clock edge n, a `boundary` sampled on edge n+3 takes it, with `take_smi` high in the following cycle; a boundary on edge n+2 or earlier does not.
- R6: When an SMI is pending and `nmi_req` is 1 at the same boundary, `take_smi` pulses and `take_nmi` stays 0.
- R7: `in_handler` rises in the same cycle as `take_smi`, stays 1 until a clock samples `resume` at 1, and no `take_smi` occurs while it is 1; `take_smi` lasts one cycle.
- R8: While `in_handler` is 1, any number of new edges is remembered as exactly one request.
- R9: A remembered request is taken at the first boundary after resume: with `boundary` held at 1, `take_smi` pulses two cycles after the cycle in which `resume` is driven.
- R10: `take_nmi` is a one-cycle pulse that follows a clock where `boundary` is 1, `locked` is 0, `nmi_req` is 1 and no SMI is taken; `take_smi` and `take_nmi` are never 1 together.
- R11: Reset clears the pending flag and the handler state, drives both take outputs to 0, and leaves the detector armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smi_n | input | 1 | Raw asynchronous SMI request, active low |
| boundary | input | 1 | Instruction-boundary strobe from the sequencer |
| locked | input | 1 | High while a locked bus sequence is in progress |
| nmi_req | input | 1 | NMI request competing at the boundary |
| resume | input | 1 | Strobe marking the end of the SMI handler |
| take_smi | output | 1 | One-cycle pulse: enter the SMI handler now |
| take_nmi | output | 1 | One-cycle pulse: enter the NMI handler now |
| in_handler | output | 1 | High while the SMI handler runs; SMI is masked |

## Verification
The bench sweeps the re-arm gap from one to seven high clocks. A detector that counted wrongly would drop a request legitimately separated by four clocks, or it would accept one after only three. It also sweeps the low width and the boundary offset. This exposes a level-sensitive design, which would queue a second request from one long pulse. It also exposes a design with the wrong synchronizer depth, which would take the request one boundary early or late. Further tests stack several edges inside a handler, apply reset with a request pending, and hold `locked` across a boundary. A queue deeper than one bit, a reset that forgot the pending flag, or a take inside a locked sequence each shows up as an extra or misplaced `take_smi`.

// File: rtl/smi_gate_pkg.sv
`timescale 1ns/1ps
package smi_gate_pkg;

    // Falling-edge detector with re-arm interval
    typedef enum logic [1:0] {
        EDG_ARMED   = 2'd0,
        EDG_LOW     = 2'd1,
        EDG_RECOVER = 2'd2
    } edg_state_t;

    // Handler arbitration
    typedef enum logic {
        ARB_APP = 1'b0,
        ARB_SMM = 1'b1
    } arb_state_t;

endpackage

// File: rtl/smi_sync.sv
`timescale 1ns/1ps
module smi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic lvl_n
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_n};
        end
    end

    assign lvl_n = chain_q[STAGES-1];
endmodule

// File: rtl/smi_edge.sv
`timescale 1ns/1ps
module smi_edge
    import smi_gate_pkg::*;
#(
    parameter int REARM = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_n,
    output logic fall
);
    localparam int CW = (REARM > 2) ? $clog2(REARM) : 1;
    localparam logic [CW-1:0] LAST = CW'(REARM - 1);

    edg_state_t       state_q, state_d;
    logic [CW-1:0]    cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EDG_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fall    = 1'b0;
        unique case (state_q)
            EDG_ARMED: begin
                if (!lvl_n) begin
                    fall    = 1'b1;
                    state_d = EDG_LOW;
                end
            end
            EDG_LOW: begin
                if (lvl_n) begin
                    state_d = EDG_RECOVER;
                    cnt_d   = CW'(1);
                end
            end
            EDG_RECOVER: begin
                if (!lvl_n) begin
                    state_d = EDG_LOW;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = EDG_ARMED;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = EDG_ARMED;
                cnt_d   = '0;
            end
        endcase
    end
endmodule

// File: rtl/smi_arb.sv
`timescale 1ns/1ps
module smi_arb
    import smi_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic boundary,
    input  logic locked,
    input  logic nmi_req,
    input  logic resume,
    output logic take_smi,
    output logic take_nmi,
    output logic in_handler
);
    arb_state_t state_q, state_d;
    logic       pend_q, pend_d;
    logic       go_smi, go_nmi;
    logic       smi_q, nmi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_APP;
            pend_q  <= 1'b0;
            smi_q   <= 1'b0;
            nmi_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            smi_q   <= go_smi;
            nmi_q   <= go_nmi;
        end
    end

    always_comb begin
        state_d = state_q;
        go_smi  = 1'b0;
        unique case (state_q)
            ARB_APP: begin
                if (boundary && !locked && pend_q) begin
                    go_smi  = 1'b1;
                    state_d = ARB_SMM;
                end
            end
            ARB_SMM: begin
                if (resume) begin
                    state_d = ARB_APP;
                end
            end
            default: state_d = ARB_APP;
        endcase
        go_nmi = boundary && !locked && nmi_req && !go_smi;
        pend_d = go_smi ? fall : (pend_q | fall);
    end

    assign take_smi   = smi_q;
    assign take_nmi   = nmi_q;
    assign in_handler = (state_q == ARB_SMM);
endmodule

// File: rtl/smi_gate.sv
`timescale 1ns/1ps
module smi_gate #(
    parameter int SYNC_STAGES = 2,
    parameter int REARM_CLKS  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smi_n,
    input  logic boundary,
    input  logic locked,
    input  logic nmi_req,
    input  logic resume,
    output logic take_smi,
    output logic take_nmi,
    output logic in_handler
);
    logic lvl_n;
    logic fall;

    smi_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (smi_n),
        .lvl_n (lvl_n)
    );

    smi_edge #(.REARM(REARM_CLKS)) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_n (lvl_n),
        .fall  (fall)
    );

    smi_arb i_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall       (fall),
        .boundary   (boundary),
        .locked     (locked),
        .nmi_req    (nmi_req),
        .resume     (resume),
        .take_smi   (take_smi),
        .take_nmi   (take_nmi),
        .in_handler (in_handler)
    );
endmodule

// File: rtl/smi_gate_chk.sv
`timescale 1ns/1ps
module smi_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic boundary,
    input logic locked,
    input logic nmi_req,
    input logic resume,
    input logic take_smi,
    input logic take_nmi,
    input logic in_handler
);
    p_excl_takes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_smi && take_nmi));

    p_smi_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_smi |=> !take_smi);

    p_enter_handler_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_smi |-> in_handler);

    p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_smi |-> !$past(in_handler));

    p_hold_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_handler && !resume) |=> in_handler);

    p_leave_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_handler && resume) |=> !in_handler);

    p_boundary_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_smi |-> $past(boundary && !locked));

    p_nmi_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |-> $past(boundary && !locked && nmi_req));
endmodule

bind smi_gate smi_gate_chk i_smi_gate_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary   (boundary),
    .locked     (locked),
    .nmi_req    (nmi_req),
    .resume     (resume),
    .take_smi   (take_smi),
    .take_nmi   (take_nmi),
    .in_handler (in_handler)
);

// File: tb/test_smi_gate.sv
`timescale 1ns/1ps
module test_smi_gate;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smi_n = 1'b1;
    logic boundary = 1'b0;
    logic locked = 1'b0;
    logic nmi_req = 1'b0;
    logic resume = 1'b0;
    logic take_smi, take_nmi, in_handler;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    smi_gate i_smi_gate (
        .clk(clk), .rst_n(rst_n), .smi_n(smi_n), .boundary(boundary),
        .locked(locked), .nmi_req(nmi_req), .resume(resume),
        .take_smi(take_smi), .take_nmi(take_nmi), .in_handler(in_handler)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; smi_n = 1'b1; boundary = 1'b0;
        locked = 1'b0; nmi_req = 1'b0; resume = 1'b0;
        repeat (2) cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    task automatic pulse();
        smi_n = 1'b0; cyc(); smi_n = 1'b1;
    endtask

    task automatic count_smi(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            cyc();
            c += int'(take_smi);
        end
    endtask

    task automatic do_resume();
        resume = 1'b1; cyc(); resume = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        int c, first;
        do_reset();
        // R11: reset state
        chk("R11 take_smi after reset", take_smi, 0);
        chk("R11 take_nmi after reset", take_nmi, 0);
        chk("R11 in_handler after reset", in_handler, 0);

        // R11: reset clears a pending request
        pulse(); repeat (6) cyc();
        do_reset();
        boundary = 1'b1;
        count_smi(8, c);
        chk("R11 pending cleared by reset", c, 0);

        // R1, R2, R5: width sweep, latency and single request
        for (int w = 1; w <= 6; w++) begin
            do_reset();
            boundary = 1'b1;
            smi_n = 1'b0;
            first = 0; c = 0;
            for (int s = 1; s <= 12; s++) begin
                cyc();
                if (s == w) smi_n = 1'b1;
                if (take_smi) begin
                    c++;
                    if (first == 0) first = s;
                end
            end
            chk($sformatf("R2 one take for low width %0d", w), c, 1);
            chk($sformatf("R5 take latency width %0d", w), first, 4);
            chk("R7 in_handler after take", in_handler, 1);
            do_resume();
            count_smi(8, c);
            chk($sformatf("R1 no extra request width %0d", w), c, 0);
        end

        // R3: re-arm gap sweep
        for (int h = 1; h <= 7; h++) begin
            do_reset();
            boundary = 1'b1;
            pulse();
            repeat (h) cyc();
            pulse();
            repeat (8) cyc();
            do_resume();
            count_smi(8, c);
            chk($sformatf("R3 second edge after %0d high clocks", h), c, (h >= 4) ? 1 : 0);
        end

        // R5: boundary offset sweep
        for (int d = 1; d <= 5; d++) begin
            do_reset();
            smi_n = 1'b0; cyc(); smi_n = 1'b1;
            for (int s = 2; s <= d; s++) cyc();
            boundary = 1'b1; cyc(); boundary = 1'b0;
            chk($sformatf("R5 boundary at offset %0d", d), take_smi, (d >= 3) ? 1 : 0);
        end

        // R8, R9: one queued request while masked
        do_reset();
        boundary = 1'b1;
        pulse(); repeat (8) cyc();
        for (int k = 0; k < 3; k++) begin
            pulse(); repeat (6) cyc();
        end
        resume = 1'b1; cyc(); resume = 1'b0;
        chk("R9 no take in cycle after resume", take_smi, 0);
        chk("R7 handler left on resume", in_handler, 0);
        cyc();
        chk("R9 queued take at first boundary", take_smi, 1);
        repeat (3) cyc();
        do_resume();
        count_smi(8, c);
        chk("R8 only one request queued", c, 0);

        // R7: mask holds without resume
        do_reset();
        boundary = 1'b1;
        pulse(); repeat (6) cyc();
        c = 0;
        for (int k = 0; k < 24; k++) begin
            if (k % 6 == 0) smi_n = 1'b0; else smi_n = 1'b1;
            cyc();
            if (!in_handler || take_smi) c++;
        end
        chk("R7 masked cycles with violation", c, 0);

        // R4: locked defers the take
        do_reset();
        boundary = 1'b1; locked = 1'b1;
        pulse();
        count_smi(10, c);
        chk("R4 no take while locked", c, 0);
        locked = 1'b0; cyc();
        chk("R4 take once unlocked", take_smi, 1);

        // R4: no boundary, no take
        do_reset();
        pulse();
        count_smi(10, c);
        chk("R4 no take without boundary", c, 0);
        boundary = 1'b1; cyc(); boundary = 1'b0;
        chk("R4 take at boundary", take_smi, 1);

        // R6, R10: priority and NMI path
        do_reset();
        nmi_req = 1'b1;
        pulse(); repeat (6) cyc();
        boundary = 1'b1; cyc(); boundary = 1'b0;
        chk("R6 smi wins", take_smi, 1);
        chk("R6 nmi held off", take_nmi, 0);
        do_resume(); cyc();
        boundary = 1'b1; cyc(); boundary = 1'b0;
        chk("R10 nmi taken", take_nmi, 1);
        chk("R10 no smi with nmi", take_smi, 0);
        cyc();
        chk("R10 nmi pulse one cycle", take_nmi, 0);
        locked = 1'b1; boundary = 1'b1;
        c = 0;
        for (int k = 0; k < 4; k++) begin
            cyc(); c += int'(take_nmi);
        end
        chk("R10 no nmi while locked", c, 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule